// File: doc/BRIEF.md
# Reset and Power-Fail Output Sequencer

This block is the digital core of a supply supervisor. Two active-low external reset requests enter through synchronizers. Each then passes a low-time qualifier, so a short glitch is dropped and a sustained low produces a reset. The reset output stays asserted for as long as a qualified request is held. After the request goes away, the output is stretched by a recovery interval. The same interval follows power-on and the return of main power. The reset pin is modelled as an open-drain pad: the block drives it low or releases it.

Two power-fail outputs follow already-digitized comparator results. During battery back-up (supply-valid low) both outputs are held low. When main power comes back, both are forced high for one recovery interval, whatever the comparators show. After that interval each output tracks its own comparator. A configuration bit selects whether these two outputs behave as open-drain or as push-pull, and the block supplies a value and an enable for each pad.

The recovery interval is a cycle count computed from a clock-frequency parameter. A two-bit code selects one of four preset lengths.

Top module: `rst_pf_seq`

## Requirements
- R1: A low on either reset request that lasts fewer than QUAL_CYC consecutive clock cycles never asserts the reset output.
- R2: A low on either reset request that lasts at least QUAL_CYC consecutive cycles asserts the reset output within QUAL_CYC+4 cycles of its falling edge.
- R3: The reset output stays asserted while a qualified request is held low. It is released N+3 cycles (within ±2) after the request returns high, where N is the recovery length.
- R4: The recovery code gives N = CLK_HZ/1000 times 1, 4, 24 or 96 for codes 0, 1, 2 and 3. Code 3 is the 96 ms default. The code in effect is the one present at the last reload of the interval, so a later change of the code does not alter a running interval.
- R5: While the power-on reset is active, the reset output is asserted and both power-fail outputs are low. After power-on reset is released with supply valid, the reset output stays asserted for N+2 cycles (within ±2).
- R6: A qualified request that arrives while the interval is running restarts the interval. The release then falls N+3 cycles (within ±2) after the new request ends.
- R7: The reset output has open-drain form. rst_drive_en=1 means the pad pulls low, and then rst_out_n=0. rst_drive_en=0 means the pad is released and rst_out_n reads 1.
- R8: While supply_ok is low, both power-fail outputs are 0 and the reset output is asserted, regardless of the comparator inputs.
- R9: After supply_ok rises, both power-fail outputs read 1 from 3 cycles after the rise until about N cycles after it, regardless of the comparators. From N+4 cycles onward they follow the comparators.
- R10: In normal operation pf_out[i] equals pf_ok[i] one cycle later. pf_ok=1 means the monitored input is above threshold.
- R11: When pf_od=1, pf_oe[i] = NOT pf_out[i], so a high output is an undriven pad. When pf_od=0, pf_oe is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| rst_req1_n | input | 1 | External reset request 1, active low, asynchronous |
| rst_req2_n | input | 1 | External reset request 2, active low, asynchronous |
| supply_ok | input | 1 | 1 = main power, 0 = battery back-up |
| pf_ok | input | 2 | Digitized comparator results, 1 = above threshold |
| rec_sel | input | 2 | Recovery length code |
| pf_od | input | 1 | 1 = power-fail outputs open-drain, 0 = push-pull |
| rst_out_n | output | 1 | Reset output level |
| rst_drive_en | output | 1 | Reset pad pull-down enable |
| pf_out | output | 2 | Power-fail output values |
| pf_oe | output | 2 | Power-fail pad drive enables |

## Verification
Reset requests are tried as low pulses of random length below the qualifier and exactly one short of it, which must leave the reset output untouched. They are also tried at exactly the qualifier length and as long holds, which must assert it, so that an off-by-one in the qualifier shows up. Release timing is measured under each recovery code. It is also measured with the code changed in the middle of an interval and with a second request in the middle of an interval, which separates a correct reload from a free-running or a latched-once timer. Power-fail outputs are tried with random comparator and drive-style patterns in normal mode, with comparator toggling during back-up, and across a power return with the comparators reading low, which separates the forced-high window from plain tracking.

// File: rtl/rps_pkg.sv
package rps_pkg;

  // Milliseconds for each recovery code.
  function automatic int unsigned rec_ms(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 24;
      default: return 96;
    endcase
  endfunction

  // Recovery length in clock cycles.
  function automatic int unsigned rec_cycles(input logic [1:0] code,
                                             input int unsigned cyc_per_ms);
    return rec_ms(code) * cyc_per_ms;
  endfunction

endpackage

// File: rtl/rps_sync.sv
module rps_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/rps_glitch_qual.sv
module rps_glitch_qual #(
  parameter int unsigned QUAL_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_n,
  output logic held
);
  localparam int unsigned QW = $clog2(QUAL_CYC + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_CYC);

  logic [QW-1:0] low_cnt;

  assign held = (low_cnt == QMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      low_cnt <= '0;
    else if (in_n)
      low_cnt <= '0;
    else if (!held)
      low_cnt <= low_cnt + 1'b1;
  end
endmodule

// File: rtl/rps_rec_timer.sv
module rps_rec_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy
);
  logic [CW-1:0] cnt;

  assign busy = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (busy)
      cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/rst_pf_seq.sv
module rst_pf_seq #(
  parameter int unsigned CLK_HZ   = 200_000_000,
  parameter int unsigned QUAL_CYC = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_req1_n,
  input  logic       rst_req2_n,
  input  logic       supply_ok,
  input  logic [1:0] pf_ok,
  input  logic [1:0] rec_sel,
  input  logic       pf_od,
  output logic       rst_out_n,
  output logic       rst_drive_en,
  output logic [1:0] pf_out,
  output logic [1:0] pf_oe
);
  localparam int unsigned CPMS   = CLK_HZ / 1000;
  localparam int unsigned MAXLEN = rps_pkg::rec_cycles(2'd3, CPMS);
  localparam int unsigned CW     = $clog2(MAXLEN + 1);
  localparam int unsigned NREQ   = 2;
  localparam int unsigned NPF    = 2;

  // Named internal events used by the checker.
  logic [NREQ-1:0] req_s;
  logic            sup_s;
  logic [NREQ-1:0] held;
  logic            qual_hold;
  logic            por_q;
  logic            rst_load;
  logic            pf_load;
  logic            rst_busy;
  logic            pf_busy;
  logic [CW-1:0]   load_val;
  logic            rst_assert;
  logic [NPF-1:0]  pf_q;

  rps_sync #(.W(NREQ + 1), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({supply_ok, rst_req2_n, rst_req1_n}),
    .q({sup_s, req_s})
  );

  for (genvar g = 0; g < NREQ; g++) begin : g_qual
    rps_glitch_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
      .clk(clk), .rst_n(rst_n), .in_n(req_s[g]), .held(held[g])
    );
  end

  assign qual_hold = |held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) por_q <= 1'b1;
    else        por_q <= 1'b0;
  end

  assign load_val = CW'(rps_pkg::rec_cycles(rec_sel, CPMS));
  assign rst_load = por_q | qual_hold | ~sup_s;
  assign pf_load  = por_q | ~sup_s;

  rps_rec_timer #(.CW(CW)) u_rst_tmr (
    .clk(clk), .rst_n(rst_n), .load(rst_load), .load_val(load_val), .busy(rst_busy)
  );

  rps_rec_timer #(.CW(CW)) u_pf_tmr (
    .clk(clk), .rst_n(rst_n), .load(pf_load), .load_val(load_val), .busy(pf_busy)
  );

  assign rst_assert   = rst_busy | rst_load;
  assign rst_drive_en = rst_assert;
  assign rst_out_n    = ~rst_assert;

  for (genvar p = 0; p < NPF; p++) begin : g_pf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pf_q[p] <= 1'b0;
      else if (!sup_s)           pf_q[p] <= 1'b0;
      else if (pf_busy | pf_load) pf_q[p] <= 1'b1;
      else                       pf_q[p] <= pf_ok[p];
    end
    assign pf_oe[p] = pf_od ? ~pf_q[p] : 1'b1;
  end

  assign pf_out = pf_q;
endmodule

// File: rtl/rst_pf_seq_chk.sv
module rst_pf_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sup_s,
  input logic       qual_hold,
  input logic       pf_busy,
  input logic       pf_load,
  input logic [1:0] pf_ok,
  input logic       pf_od,
  input logic       rst_drive_en,
  input logic       rst_out_n,
  input logic [1:0] pf_out,
  input logic [1:0] pf_oe
);
  a_r3_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_drive_en) |-> $past(sup_s && !qual_hold));

  a_r8_backup_pf_low: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_s |=> (pf_out == 2'b00));

  a_r8_backup_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_s |-> (rst_drive_en && !rst_out_n));

  a_r9_return_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_s && pf_busy) |=> (pf_out == 2'b11));

  a_r10_track: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_s && !pf_busy && !pf_load) |=> (pf_out == $past(pf_ok)));

  a_r11_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
    pf_od |-> ((pf_oe & pf_out) == 2'b00));

  a_r11_push_pull: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_od |-> (pf_oe == 2'b11));
endmodule

bind rst_pf_seq rst_pf_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sup_s(sup_s), .qual_hold(qual_hold),
  .pf_busy(pf_busy), .pf_load(pf_load), .pf_ok(pf_ok), .pf_od(pf_od),
  .rst_drive_en(rst_drive_en), .rst_out_n(rst_out_n),
  .pf_out(pf_out), .pf_oe(pf_oe)
);

// File: tb/rst_pf_seq_test.sv
`timescale 1ns/1ps
module rst_pf_seq_test;
  localparam int CPMS = 20;
  localparam int QUAL = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rst_req1_n, rst_req2_n, supply_ok, pf_od;
  logic [1:0] pf_ok, rec_sel;
  logic       rst_out_n, rst_drive_en;
  logic [1:0] pf_out, pf_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rst_pf_seq #(.CLK_HZ(CPMS * 1000), .QUAL_CYC(QUAL)) uut (
    .clk(clk), .rst_n(rst_n), .rst_req1_n(rst_req1_n), .rst_req2_n(rst_req2_n),
    .supply_ok(supply_ok), .pf_ok(pf_ok), .rec_sel(rec_sel), .pf_od(pf_od),
    .rst_out_n(rst_out_n), .rst_drive_en(rst_drive_en), .pf_out(pf_out), .pf_oe(pf_oe)
  );

  function automatic int exp_len(input logic [1:0] s);
    int ms [4] = '{1, 4, 24, 96};
    return ms[s] * CPMS;
  endfunction

  function automatic logic [1:0] exp_oe(input logic od, input logic [1:0] v);
    return od ? ~v : 2'b11;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Cycles until the reset pad is released, counted at falling edges.
  task automatic time_release(output int k);
    k = 0;
    while (rst_drive_en && k < 5000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic pulse(input int which, input int len);
    if (which == 0) rst_req1_n = 1'b0; else rst_req2_n = 1'b0;
    cyc(len);
    rst_req1_n = 1'b1;
    rst_req2_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_run();
    end
  end

  initial begin
    int k, n;
    bit seen;
    void'($urandom(32'd1234));
    rst_n = 1'b0; rst_req1_n = 1'b1; rst_req2_n = 1'b1;
    supply_ok = 1'b1; pf_ok = 2'b00; rec_sel = 2'd3; pf_od = 1'b0;
    cyc(3);
    // R5 reset state, R7 level form
    check(rst_drive_en == 1'b1, "R5 drive_en in reset", int'(rst_drive_en), 1);
    check(rst_out_n == 1'b0, "R7 level while driven", int'(rst_out_n), 0);
    check(pf_out == 2'b00, "R5 pf in reset", int'(pf_out), 0);
    rst_n = 1'b1;
    n = exp_len(2'd3);
    time_release(k);
    check(k >= n && k <= n + 4, "R5 power-on stretch (R4 code 3)", k, n + 2);
    check(rst_out_n == 1'b1, "R7 released level", int'(rst_out_n), 1);

    // R10 / R11 random comparator and drive style
    rec_sel = 2'd0;
    cyc(5);
    for (int i = 0; i < 40; i++) begin
      logic [1:0] v;
      v = 2'($urandom_range(0, 3));
      pf_ok = v;
      pf_od = 1'($urandom_range(0, 1));
      cyc(1);
      check(pf_out == v, "R10 tracking", int'(pf_out), int'(v));
      check(pf_oe == exp_oe(pf_od, v), "R11 drive enable", int'(pf_oe), int'(exp_oe(pf_od, v)));
    end

    // R1 short glitches, including one short of the limit
    for (int i = 0; i < 12; i++) begin
      int len;
      len = (i < 2) ? QUAL - 1 : $urandom_range(1, QUAL - 1);
      seen = 1'b0;
      pulse(i % 2, len);
      for (int j = 0; j < QUAL + 6; j++) begin
        cyc(1);
        if (rst_drive_en) seen = 1'b1;
      end
      check(!seen, "R1 glitch ignored", int'(seen), 0);
    end

    // R2 exactly QUAL cycles, then R3 release with code 0
    seen = 1'b0;
    rst_req2_n = 1'b0;
    for (int j = 0; j < QUAL; j++) begin
      cyc(1);
      if (rst_drive_en) seen = 1'b1;
    end
    rst_req2_n = 1'b1;
    for (int j = 0; j < 4; j++) begin
      if (rst_drive_en) seen = 1'b1;
      if (!seen) cyc(1);
    end
    check(seen, "R2 qualified request asserts", int'(seen), 1);
    n = exp_len(2'd0);
    time_release(k);
    k = k + QUAL + 4;
    check(k >= n + 1 && k <= n + 3 + 2 + QUAL + 4, "R3 release after exact pulse", k, n + 3);

    // R3 long hold on input 1, code 1
    rec_sel = 2'd1;
    rst_req1_n = 1'b0;
    cyc(50);
    check(rst_drive_en == 1'b1, "R3 held while low", int'(rst_drive_en), 1);
    rst_req1_n = 1'b1;
    n = exp_len(2'd1);
    time_release(k);
    check(k >= n + 1 && k <= n + 5, "R3 release code 1", k, n + 3);

    // R4 code 2, then code changed mid-interval has no effect
    rec_sel = 2'd2;
    pulse(0, 10);
    cyc(10);
    rec_sel = 2'd0;
    n = exp_len(2'd2);
    time_release(k);
    k = k + 10;
    check(k >= n + 1 && k <= n + 5, "R4 code 2 with late code change", k, n + 3);

    // R6 restart by a second request
    rec_sel = 2'd1;
    n = exp_len(2'd1);
    pulse(1, 10);
    cyc(n / 2);
    check(rst_drive_en == 1'b1, "R6 mid interval", int'(rst_drive_en), 1);
    pulse(0, 10);
    time_release(k);
    check(k >= n + 1 && k <= n + 5, "R6 restart", k, n + 3);

    // R8 back-up
    pf_od = 1'b0;
    pf_ok = 2'b11;
    supply_ok = 1'b0;
    cyc(5);
    for (int i = 0; i < 6; i++) begin
      pf_ok = 2'($urandom_range(0, 3));
      cyc(1);
      check(pf_out == 2'b00, "R8 pf low in back-up", int'(pf_out), 0);
      check(rst_drive_en == 1'b1, "R8 reset in back-up", int'(rst_drive_en), 1);
    end

    // R9 power return
    pf_ok = 2'b00;
    supply_ok = 1'b1;
    cyc(3);
    check(pf_out == 2'b11, "R9 forced high early", int'(pf_out), 3);
    cyc(n - 8);
    check(pf_out == 2'b11, "R9 forced high late", int'(pf_out), 3);
    cyc(13);
    check(pf_out == 2'b00, "R9 follows after interval", int'(pf_out), 0);
    pf_ok = 2'b10;
    cyc(1);
    check(pf_out == 2'b10, "R10 tracking after return", int'(pf_out), 2);

    done = 1'b1;
    finish_run();
  end
endmodule